// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block arbitrates eight interrupt request lines for a host processor. The host programs it through a two-address register port. Address 0 is the command address and address 1 is the data address. A short initialization sequence first sets the vector base, the cascade configuration and the operating mode. After that, data-address writes load the interrupt mask.

The block keeps three registers: a request register, an in-service register and a mask. It ranks the lines in a circular priority order whose lowest-priority line can be programmed. It raises its interrupt output when an unmasked request outranks everything already being serviced. A one-cycle acknowledge pulse then returns the vector for the winning line. End-of-interrupt commands retire in-service lines, and an automatic end-of-interrupt mode removes the need for them. Inputs can be edge or level sensitive.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `int_out` and `vec_out` are 0, the mask reads 0xFF at address 1, address 0 returns the request register (0 with all inputs low), and `casc_word` is 0.
- R2: A command-address write with bit 4 set is an initialization command. It clears the mask, the in-service register and the edge latches. It also selects the request register for reads and sets the lowest-priority line to 7. The next data writes go in order to the vector base, then the cascade word (skipped when bit 1 is set), then the mode word (only when bit 0 is set). After that, data writes load the mask.
- R3: When `ack` is high while `int_out` is high, `vec_out` in the same cycle equals the vector base plus the winning line index, modulo 256. Otherwise `vec_out` is 0. The winning line moves into the in-service register.
- R4: When `role_master` is 1, the cascade word is stored as a full 8-bit line bitmap on `casc_word`. When `role_master` is 0, only bits 2:0 (the master line number) are kept and the upper bits read 0.
- R5: When bit 1 of the mode word is set (automatic end-of-interrupt), an acknowledge sets no in-service bit.
- R6: In edge mode (initialization bit 3 clear), a request bit is latched on a rising input and cleared by its acknowledge. A line held high does not latch again until it falls and rises.
- R7: In level mode (initialization bit 3 set), the request register follows the inputs directly.
- R8: A set mask bit keeps that line from raising `int_out`. Reads of address 1 return the mask.
- R9: A command with bits 4:3 = 01 and bit 1 set selects what address 0 reads: the in-service register when bit 0 = 1, the request register when bit 0 = 0. With bit 1 clear, the selection does not change.
- R10: The command 0x20 (bits 4:3 = 00, bit 5 end-of-interrupt, bit 6 clear) clears the highest-priority in-service bit.
- R11: The command 0x60|L (bits 6 and 5 set) clears the in-service bit of line L.
- R12: The command 0xC0|L (bits 7 and 6 set, bit 5 clear) makes line L the lowest priority. Priority then runs L+1, L+2, … around to L.
- R13: `int_out` is high only when an unmasked request has strictly higher priority than every in-service line.
- R14: An end-of-interrupt command with bit 7 also set (for example 0xA0) makes the line it cleared the new lowest-priority line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| role_master | input | 1 | 1 = master role, 0 = slave role for the cascade word |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the host |
| ack | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Vector returned during an acknowledge |
| casc_word | output | 8 | Stored cascade configuration |

## Verification
Some assertions assume that an acknowledge and an end-of-interrupt write never land in the same cycle. Others assume that the trigger mode changes only through an initialization command. The stimulus keeps inputs steady across a clock edge and issues acknowledges, commands and request changes in separate cycles. It also sets `role_master` before starting an initialization. It never writes a data byte before the command that opens an initialization sequence.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  parameter int PIC_LINES = 8;
  parameter int PIC_DW    = 8;
  localparam int PIC_IW   = $clog2(PIC_LINES);

  typedef logic [PIC_IW-1:0]    line_t;
  typedef logic [PIC_LINES-1:0] lvec_t;
  typedef logic [PIC_DW-1:0]    byte_t;

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} init_st_t;

  typedef struct packed {
    logic  found;
    line_t idx;
  } pick_t;

  // rank 0 is the highest priority: the line just after the lowest one
  function automatic line_t rank_of(line_t idx, line_t lowest);
    return line_t'(idx - lowest - line_t'(1));
  endfunction

  // highest-priority set bit of v under the given lowest line
  function automatic pick_t pick_top(lvec_t v, line_t lowest);
    pick_t r;
    r = '0;
    for (int k = PIC_LINES - 1; k >= 0; k--) begin
      line_t ln;
      ln = line_t'(lowest + line_t'(k + 1));
      if (v[ln]) r = {1'b1, ln};
    end
    return r;
  endfunction

  function automatic byte_t vec_of(byte_t base, line_t idx);
    return byte_t'(base + byte_t'(idx));
  endfunction

  function automatic lvec_t onehot_of(line_t idx);
    return lvec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/pic_cfg.sv
`timescale 1ns/1ps
module pic_cfg
  import pic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  addr,
  input  byte_t wdata,
  input  logic  role_master,
  input  pick_t isr_top,
  output byte_t base,
  output byte_t casc_word,
  output lvec_t mask,
  output logic  rsel_isr,
  output logic  level_mode,
  output logic  aeoi,
  output line_t lowest,
  output logic  init_pulse,
  output lvec_t isr_clr,
  output logic  nseoi_cmd
);
  init_st_t st;
  logic  need_mode, single;
  logic  wr_cmd, wr_dat, rsel_cmd, ocw_cmd, eoi_hit, rot_load;
  line_t lvl, eoi_idx, rot_idx;

  always_comb begin
    wr_cmd     = wr_en & ~addr;
    wr_dat     = wr_en & addr;
    lvl        = wdata[PIC_IW-1:0];
    init_pulse = wr_cmd & wdata[4];
    rsel_cmd   = wr_cmd & (wdata[4:3] == 2'b01);
    ocw_cmd    = wr_cmd & (wdata[4:3] == 2'b00);
    eoi_idx    = wdata[6] ? lvl : isr_top.idx;
    eoi_hit    = ocw_cmd & wdata[5] & (wdata[6] | isr_top.found);
    isr_clr    = eoi_hit ? onehot_of(eoi_idx) : '0;
    nseoi_cmd  = ocw_cmd & wdata[5] & ~wdata[6];
    rot_load   = ocw_cmd & wdata[7] & (eoi_hit | (wdata[6] & ~wdata[5]));
    rot_idx    = wdata[5] ? eoi_idx : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      need_mode  <= 1'b0;
      single     <= 1'b0;
      level_mode <= 1'b0;
      aeoi       <= 1'b0;
      rsel_isr   <= 1'b0;
      lowest     <= '1;
      mask       <= '1;
      base       <= '0;
      casc_word  <= '0;
    end else if (init_pulse) begin
      st         <= ST_BASE;
      need_mode  <= wdata[0];
      single     <= wdata[1];
      level_mode <= wdata[3];
      aeoi       <= 1'b0;
      rsel_isr   <= 1'b0;
      lowest     <= '1;
      mask       <= '0;
    end else if (wr_cmd) begin
      if (rsel_cmd && wdata[1]) rsel_isr <= wdata[0];
      if (rot_load) lowest <= rot_idx;
    end else if (wr_dat) begin
      case (st)
        ST_RUN:  mask <= lvec_t'(wdata);
        ST_BASE: begin
          base <= wdata;
          if (!single)       st <= ST_CASC;
          else if (need_mode) st <= ST_MODE;
          else               st <= ST_RUN;
        end
        ST_CASC: begin
          casc_word <= role_master ? wdata : byte_t'(lvl);
          st <= need_mode ? ST_MODE : ST_RUN;
        end
        default: begin
          aeoi <= wdata[1];
          st   <= ST_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/pic_req.sv
`timescale 1ns/1ps
module pic_req
  import pic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lvec_t irq_in,
  input  logic  level_mode,
  input  logic  init_pulse,
  input  lvec_t ack_clr,
  output lvec_t irr
);
  lvec_t prev, edge_lat, rise;

  assign rise = irq_in & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      edge_lat <= '0;
    end else begin
      prev <= irq_in;
      if (init_pulse) edge_lat <= '0;
      else            edge_lat <= (edge_lat & ~ack_clr) | rise;
    end
  end

  assign irr = level_mode ? irq_in : edge_lat;
endmodule

// File: rtl/pic_isr.sv
`timescale 1ns/1ps
module pic_isr
  import pic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init_pulse,
  input  lvec_t set_vec,
  input  lvec_t clr_vec,
  output lvec_t isr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          isr <= '0;
    else if (init_pulse) isr <= '0;
    else                 isr <= (isr | set_vec) & ~clr_vec;
  end
endmodule

// File: rtl/pic_resolve.sv
`timescale 1ns/1ps
module pic_resolve
  import pic_pkg::*;
(
  input  lvec_t irr,
  input  lvec_t mask,
  input  lvec_t isr,
  input  line_t lowest,
  output pick_t req_top,
  output pick_t isr_top,
  output lvec_t grant,
  output logic  int_req
);
  always_comb begin
    req_top = pick_top(irr & ~mask, lowest);
    isr_top = pick_top(isr, lowest);
    int_req = req_top.found &&
              (!isr_top.found ||
               (rank_of(req_top.idx, lowest) < rank_of(isr_top.idx, lowest)));
    grant   = int_req ? onehot_of(req_top.idx) : '0;
  end
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        role_master,
  input  logic [7:0]  irq_in,
  output logic        int_out,
  input  logic        ack,
  output logic [7:0]  vec_out,
  output logic [7:0]  casc_word
);
  byte_t base;
  lvec_t mask, irr, isr, grant, isr_clr, isr_set, ack_clr;
  logic  rsel_isr, level_mode, aeoi, init_pulse, nseoi_cmd, ack_fire;
  line_t lowest;
  pick_t req_top, isr_top;

  pic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .role_master(role_master), .isr_top(isr_top), .base(base),
    .casc_word(casc_word), .mask(mask), .rsel_isr(rsel_isr),
    .level_mode(level_mode), .aeoi(aeoi), .lowest(lowest),
    .init_pulse(init_pulse), .isr_clr(isr_clr), .nseoi_cmd(nseoi_cmd)
  );

  pic_req u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .init_pulse(init_pulse), .ack_clr(ack_clr), .irr(irr)
  );

  pic_isr u_isr (
    .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse),
    .set_vec(isr_set), .clr_vec(isr_clr), .isr(isr)
  );

  pic_resolve u_res (
    .irr(irr), .mask(mask), .isr(isr), .lowest(lowest),
    .req_top(req_top), .isr_top(isr_top), .grant(grant), .int_req(int_out)
  );

  always_comb begin
    ack_fire = ack & int_out;
    ack_clr  = ack_fire ? grant : '0;
    isr_set  = (ack_fire && !aeoi) ? grant : '0;
    vec_out  = ack_fire ? vec_of(base, req_top.idx) : '0;
    rdata    = addr ? byte_t'(mask) : byte_t'(rsel_isr ? isr : irr);
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
`timescale 1ns/1ps
module pic_ctrl_chk
  import pic_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  ack,
  input logic  ack_fire,
  input logic  int_out,
  input lvec_t irr,
  input lvec_t mask,
  input lvec_t isr,
  input lvec_t grant,
  input logic  aeoi,
  input logic  level_mode,
  input logic  init_pulse,
  input lvec_t isr_clr,
  input logic  nseoi_cmd
);
  // R13
  grant_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ($countones(grant) == 1 && (grant & ~irr) == '0));

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((grant & mask) == '0));

  // R5
  aeoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && aeoi && isr_clr == '0 && !init_pulse) |=> $stable(isr));

  // R3
  isr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !aeoi && isr_clr == '0 && !init_pulse)
      |=> (isr == ($past(isr) | $past(grant))));

  // R10
  ns_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nseoi_cmd && isr != '0 && !ack_fire)
      |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (isr == '0 && mask == '0));

  // R6
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !ack && !init_pulse) |=> (($past(irr) & ~irr) == '0));
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .ack_fire(ack_fire),
  .int_out(int_out), .irr(irr), .mask(mask), .isr(isr), .grant(grant),
  .aeoi(aeoi), .level_mode(level_mode), .init_pulse(init_pulse),
  .isr_clr(isr_clr), .nseoi_cmd(nseoi_cmd)
);

// File: tb/sim_pic_ctrl.sv
`timescale 1ns/1ps
module sim_pic_ctrl;
  logic       clk = 0, rst_n = 0, wr_en = 0, addr = 0, role_master = 1, ack = 0;
  logic [7:0] wdata = 0, irq_in = 0;
  logic [7:0] rdata, vec_out, casc_word;
  logic       int_out;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pic_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .role_master(role_master), .irq_in(irq_in),
    .int_out(int_out), .ack(ack), .vec_out(vec_out), .casc_word(casc_word)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(output logic i, output logic [7:0] v);
    @(negedge clk); ack = 1; #1 i = int_out; v = vec_out;
    @(negedge clk); ack = 0;
  endtask

  task automatic do_init(input logic [7:0] cmd, b, c, m);
    wr(0, cmd); wr(1, b);
    if (!cmd[1]) wr(1, c);
    if (cmd[0]) wr(1, m);
  endtask

  function automatic logic [7:0] exp_line(input int low, input int k);
    return 8'((low + 1 + k) % 8);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic i;
    logic [7:0] bases [4] = '{8'h00, 8'h08, 8'h70, 8'hFC};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    #1 chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 vec_out", vec_out, 8'h00);
    chk("R1 casc_word", casc_word, 8'h00);
    rd(1, v); chk("R1 mask", v, 8'hFF);
    rd(0, v); chk("R1 irr", v, 8'h00);

    // R2 sequencing
    do_init(8'h13, 8'h20, 8'h00, 8'h00);
    rd(1, v); chk("R2 mask cleared", v, 8'h00);
    wr(1, 8'h5A); rd(1, v); chk("R2 mask load", v, 8'h5A);
    do_init(8'h12, 8'h30, 8'h00, 8'h00);
    wr(1, 8'h33); rd(1, v); chk("R2 no-mode mask", v, 8'h33);
    wr(1, 8'h00);
    set_irq(8'h02); do_ack(i, v); chk("R2 base w/o mode", v, 8'h31);
    set_irq(8'h00); wr(0, 8'h20);
    do_init(8'h11, 8'h40, 8'hA5, 8'h00);
    wr(1, 8'h0F); rd(1, v); chk("R2 full seq mask", v, 8'h0F);

    // R4 cascade word
    chk("R4 master map", casc_word, 8'hA5);
    role_master = 0;
    do_init(8'h11, 8'h40, 8'hA5, 8'h00);
    chk("R4 slave id", casc_word, 8'h05);
    role_master = 1;

    // R3 vector sweep over bases and lines
    foreach (bases[b]) begin
      do_init(8'h13, bases[b], 8'h00, 8'h00);
      for (int ln = 0; ln < 8; ln++) begin
        set_irq(8'(1 << ln));
        do_ack(i, v);
        chk("R13 int before ack", {7'd0, i}, 8'h01);
        chk("R3 vector", v, 8'(bases[b] + ln));
        set_irq(8'h00);
        wr(0, 8'h20);
      end
    end

    // R12 R10 R13 priority sweep
    do_init(8'h13, 8'h40, 8'h00, 8'h00);
    for (int low = 0; low < 8; low++) begin
      wr(0, 8'hC0 | 8'(low));
      set_irq(8'hFF);
      for (int k = 0; k < 8; k++) begin
        do_ack(i, v);
        chk("R12 order", v, 8'h40 + exp_line(low, k));
        #1 chk("R13 nested block", {7'd0, int_out}, 8'h00);
        wr(0, 8'h20);
      end
      rd(0, v); chk("R10 all retired", v, 8'h00);
      set_irq(8'h00);
    end

    // R14 rotate on end-of-interrupt
    do_init(8'h13, 8'h00, 8'h00, 8'h00);
    set_irq(8'h09);
    do_ack(i, v); chk("R14 first", v, 8'h00);
    wr(0, 8'hA0);
    do_ack(i, v); chk("R14 next", v, 8'h03);
    wr(0, 8'h20);
    set_irq(8'h00); set_irq(8'h09);
    do_ack(i, v); chk("R14 rotated order", v, 8'h03);
    wr(0, 8'h20);
    do_ack(i, v); chk("R14 rotated last", v, 8'h00);
    wr(0, 8'h20); set_irq(8'h00);

    // R11 specific EOI and R9 read select
    do_init(8'h13, 8'h00, 8'h00, 8'h00);
    set_irq(8'h20); do_ack(i, v); chk("R11 low first", v, 8'h05);
    set_irq(8'h24); do_ack(i, v); chk("R13 nests higher", v, 8'h02);
    wr(0, 8'h65);
    wr(0, 8'h0B); rd(0, v); chk("R11 specific clear", v, 8'h04);
    set_irq(8'h64);
    wr(0, 8'h0A); rd(0, v); chk("R9 irr select", v, 8'h40);
    wr(0, 8'h0B); rd(0, v); chk("R9 isr select", v, 8'h04);
    wr(0, 8'h08); rd(0, v); chk("R9 no change", v, 8'h04);
    wr(0, 8'h20); rd(0, v); chk("R10 nonspecific", v, 8'h00);
    set_irq(8'h00);

    // R6 edge latch
    do_init(8'h13, 8'h00, 8'h00, 8'h00);
    set_irq(8'h10);
    do_ack(i, v); chk("R6 ack", v, 8'h04);
    rd(0, v); chk("R6 held no relatch", v, 8'h00);
    wr(0, 8'h20);
    #1 chk("R6 no int", {7'd0, int_out}, 8'h00);
    set_irq(8'h00); set_irq(8'h10);
    rd(0, v); chk("R6 relatch", v, 8'h10);
    set_irq(8'h00);

    // R7 level mode
    do_init(8'h1B, 8'h00, 8'h00, 8'h00);
    set_irq(8'h41); rd(0, v); chk("R7 follow", v, 8'h41);
    set_irq(8'h01); rd(0, v); chk("R7 follow drop", v, 8'h01);
    set_irq(8'h00); rd(0, v); chk("R7 follow zero", v, 8'h00);

    // R5 automatic end-of-interrupt
    do_init(8'h13, 8'h50, 8'h00, 8'h02);
    set_irq(8'h01); do_ack(i, v); chk("R5 vector", v, 8'h50);
    wr(0, 8'h0B); rd(0, v); chk("R5 isr empty", v, 8'h00);
    set_irq(8'h81);
    #1 chk("R5 int again", {7'd0, int_out}, 8'h01);
    do_ack(i, v); chk("R5 second", v, 8'h57);
    set_irq(8'h00);

    // R8 mask
    do_init(8'h13, 8'h00, 8'h00, 8'h00);
    wr(1, 8'h01); set_irq(8'h01);
    #1 chk("R8 masked", {7'd0, int_out}, 8'h00);
    rd(1, v); chk("R8 readback", v, 8'h01);
    wr(1, 8'h00);
    #1 chk("R8 unmasked", {7'd0, int_out}, 8'h01);
    do_ack(i, v); chk("R8 vector", v, 8'h00);
    set_irq(8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule